// File: doc/BRIEF.md
# Dual-Speed Clock Divider

This block turns one source clock into three derived clocks. The processor clock has a one-third duty cycle. It runs at the source rate divided by 3 in fast mode and divided by 768 in slow mode. A companion clock runs at the same rate as the processor clock with a 50% duty cycle and starts on each falling edge of the processor clock. A peripheral clock at the source rate divided by 6, with 50% duty, runs the same way in both modes.

The speed request is a level input, and it is filtered before it can take effect. A request for slow mode must stay low for 195 consecutive enabled source cycles. A request for fast mode must stay high for 6. Any shorter excursion is treated as noise. A request that passes the filter is applied only at the end of a full processor-clock period. The processor clock therefore never shows a short pulse, and its phase relation to the 50% clock is kept across the switch.

A stop/start controller drives `run_en`. While `run_en` is low, every counter and every output holds. When `run_en` returns high, counting resumes from the same phase. All inputs are taken as synchronous to the source clock.

Top module: `dual_speed_clkdiv`

## Requirements
- R1: While `rst_n` is low, `cpu_clk`, `half_clk` and `per_clk` are 0 and `mode_fast` is 1 (fast). The first enabled rising edge after reset starts a processor period with `cpu_clk` high.
- R2: In fast mode (`mode_fast`=1), `cpu_clk` repeats every 3 source cycles: high for 1 cycle, low for 2.
- R3: In slow mode (`mode_fast`=0), `cpu_clk` repeats every 768 source cycles: high for 256 cycles, low for 512.
- R4: `half_clk` rises on the same source edge on which `cpu_clk` falls. In slow mode it stays high for 384 source cycles. In fast mode it stays high for 1.5 source cycles and falls on the following falling source edge.
- R5: `per_clk` repeats every 6 enabled source cycles: high for 3, low for 3. The speed mode has no effect on it.
- R6: `speed_sel`=0 requests slow mode. The request is accepted only on the 195th consecutive enabled rising edge that samples it low. A shorter low run leaves the mode fast.
- R7: `speed_sel`=1 requests fast mode. The request is accepted only on the 6th consecutive enabled rising edge that samples it high. A shorter high run leaves the mode slow.
- R8: An accepted request changes `mode_fast` only on the rising edge that ends a processor period, which is the edge on which `cpu_clk` rises. The new period's timing follows the new mode.
- R9: While `run_en` is low at a rising edge, `cpu_clk`, `per_clk`, `mode_fast` and the filter progress hold. Outputs resume from the held phase when `run_en` is high again. The only exception is the half-cycle tail of the fast-mode `half_clk`, which still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| speed_sel | input | 1 | Speed request level: 1 = fast, 0 = slow |
| run_en | input | 1 | 1 = run, 0 = freeze all counters and outputs |
| cpu_clk | output | 1 | Processor clock, one-third duty cycle |
| half_clk | output | 1 | 50% duty clock, rising with the processor clock's falling edge |
| per_clk | output | 1 | Peripheral clock, source / 6 |
| mode_fast | output | 1 | Current applied mode: 1 = fast, 0 = slow |

## Verification
Two events can land on the same source edge: the filter accepting a request, and the end of a processor period, where the mode is actually applied. A freeze can also arrive on that same edge. The bench provokes these collisions with directed runs of exactly 195 lows and exactly 6 highs, started at various phases. Long random segments of request levels and `run_en` gaps then cover the many other alignments. Every output is compared against a cycle model built from the requirements. The comparison happens twice per source cycle, before and after the falling edge, so a mode switch placed one cycle off, or a freeze that slips a count, shows up as a mismatch.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/speed_qualifier.sv
module speed_qualifier #(
   parameter int unsigned SLOW_HOLD = 195,
   parameter int unsigned FAST_HOLD = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic speed_sel,
   output logic req_fast
);
   import dsc_pkg::*;
   localparam int unsigned QW = cnt_width(max2(SLOW_HOLD, FAST_HOLD) + 1);

   if (SLOW_HOLD < 1 || FAST_HOLD < 1) begin : g_bad_hold
      $error("speed_qualifier: hold counts must be at least 1");
   end

   logic [QW-1:0] run_q;
   logic          req_q;
   logic [QW-1:0] need;

   assign need = speed_sel ? QW'(FAST_HOLD - 1) : QW'(SLOW_HOLD - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         req_q <= 1'b1;
      end else if (run_en) begin
         if (speed_sel == req_q) begin
            run_q <= '0;
         end else if (run_q == need) begin
            req_q <= speed_sel;
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign req_fast = req_q;

   // R6 R7: the accepted request always matches the level just sampled
   p_req_matches_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(req_q) |-> (req_q == $past(speed_sel)));

   // R6: the run counter never passes the longer hold
   p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run_q < QW'(max2(SLOW_HOLD, FAST_HOLD)));

   // R9: frozen filter keeps its progress
   p_filter_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> ($stable(run_q) && $stable(req_q)));
endmodule

// File: rtl/phase_divider.sv
module phase_divider #(
   parameter int unsigned FAST_DIV = 3,
   parameter int unsigned SLOW_DIV = 768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic req_fast,
   output logic cpu_clk,
   output logic half_rise,
   output logic mode_fast
);
   import dsc_pkg::*;
   localparam int unsigned CW       = cnt_width(max2(FAST_DIV, SLOW_DIV)) + 1;
   localparam int unsigned FAST_HI  = FAST_DIV / 3;
   localparam int unsigned SLOW_HI  = SLOW_DIV / 3;
   localparam int unsigned FAST_LEN = FAST_DIV / 2;
   localparam int unsigned SLOW_LEN = SLOW_DIV / 2;

   if (FAST_DIV < 3 || (FAST_DIV % 3) != 0 || (SLOW_DIV % 3) != 0 || SLOW_DIV < FAST_DIV)
   begin : g_bad_div
      $error("phase_divider: divide ratios must be multiples of 3, slow >= fast");
   end

   logic [CW-1:0] ph_q, ph_d;
   logic          mode_q, mode_d;
   logic          cpu_q, cpu_d;
   logic          rise_q, rise_d;
   logic          last;
   logic [CW-1:0] hi_d, len_d;

   assign last = (ph_q == (mode_q ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1)));

   always_comb begin
      if (last) begin
         ph_d   = '0;
         mode_d = req_fast;
      end else begin
         ph_d   = ph_q + 1'b1;
         mode_d = mode_q;
      end
      hi_d   = mode_d ? CW'(FAST_HI)  : CW'(SLOW_HI);
      len_d  = mode_d ? CW'(FAST_LEN) : CW'(SLOW_LEN);
      cpu_d  = (ph_d < hi_d);
      rise_d = (ph_d >= hi_d) && (ph_d < hi_d + len_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= CW'(FAST_DIV - 1);
         mode_q <= 1'b1;
         cpu_q  <= 1'b0;
         rise_q <= 1'b0;
      end else if (run_en) begin
         ph_q   <= ph_d;
         mode_q <= mode_d;
         cpu_q  <= cpu_d;
         rise_q <= rise_d;
      end
   end

   assign cpu_clk   = cpu_q;
   assign half_rise = rise_q;
   assign mode_fast = mode_q;

   // R2: fast mode high phase lasts a single source cycle
   p_fast_single_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && mode_q && cpu_q) |=> !cpu_q);

   // R3: phase counter stays inside the current period
   p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q < (mode_q ? CW'(FAST_DIV) : CW'(SLOW_DIV)));

   // R8: mode only changes where a new period begins
   p_mode_at_period_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> (ph_q == '0));
endmodule

// File: rtl/half_duty_gen.sv
module half_duty_gen #(
   parameter bit FAST_ODD = 1'b1,
   parameter bit SLOW_ODD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_fast,
   input  logic half_rise,
   output logic half_clk
);
   if (FAST_ODD || SLOW_ODD) begin : g_odd
      logic tail_q;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) tail_q <= 1'b0;
         else        tail_q <= half_rise & (mode_fast ? FAST_ODD : SLOW_ODD);
      end
      assign half_clk = half_rise | tail_q;

      // R4: the tail only extends a high phase, it never starts one
      p_tail_follows_r4: assert property (@(negedge clk) disable iff (!rst_n)
         tail_q |-> $past(half_rise));
   end else begin : g_even
      assign half_clk = half_rise;
   end
endmodule

// File: rtl/per_divider.sv
module per_divider #(
   parameter int unsigned PER_DIV = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   output logic per_clk
);
   import dsc_pkg::*;
   localparam int unsigned PW   = cnt_width(PER_DIV) + 1;
   localparam int unsigned HALF = PER_DIV / 2;

   if (PER_DIV < 2 || (PER_DIV % 2) != 0) begin : g_bad_per
      $error("per_divider: ratio must be even and at least 2");
   end

   logic [PW-1:0] pc_q, pc_d;
   logic          per_q;

   assign pc_d = (pc_q == PW'(PER_DIV - 1)) ? '0 : pc_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= PW'(PER_DIV - 1);
         per_q <= 1'b0;
      end else if (run_en) begin
         pc_q  <= pc_d;
         per_q <= (pc_d < PW'(HALF));
      end
   end

   assign per_clk = per_q;

   // R5: counter never leaves its range
   p_per_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q < PW'(PER_DIV));
endmodule

// File: rtl/dual_speed_clkdiv.sv
module dual_speed_clkdiv #(
   parameter int unsigned FAST_DIV  = 3,
   parameter int unsigned SLOW_DIV  = 768,
   parameter int unsigned PER_DIV   = 6,
   parameter int unsigned SLOW_HOLD = 195,
   parameter int unsigned FAST_HOLD = 6
) (
   input  logic clk_src,
   input  logic rst_n,
   input  logic speed_sel,
   input  logic run_en,
   output logic cpu_clk,
   output logic half_clk,
   output logic per_clk,
   output logic mode_fast
);
   localparam bit FAST_ODD = (FAST_DIV % 2) != 0;
   localparam bit SLOW_ODD = (SLOW_DIV % 2) != 0;

   logic req_fast;
   logic half_rise;

   speed_qualifier #(.SLOW_HOLD(SLOW_HOLD), .FAST_HOLD(FAST_HOLD)) u_qual (
      .clk(clk_src), .rst_n(rst_n), .run_en(run_en),
      .speed_sel(speed_sel), .req_fast(req_fast));

   phase_divider #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_phase (
      .clk(clk_src), .rst_n(rst_n), .run_en(run_en), .req_fast(req_fast),
      .cpu_clk(cpu_clk), .half_rise(half_rise), .mode_fast(mode_fast));

   half_duty_gen #(.FAST_ODD(FAST_ODD), .SLOW_ODD(SLOW_ODD)) u_half (
      .clk(clk_src), .rst_n(rst_n), .mode_fast(mode_fast),
      .half_rise(half_rise), .half_clk(half_clk));

   per_divider #(.PER_DIV(PER_DIV)) u_per (
      .clk(clk_src), .rst_n(rst_n), .run_en(run_en), .per_clk(per_clk));

   // R4: 50% clock starts on the processor clock's falling edge
   p_half_at_cpu_fall_r4: assert property (@(posedge clk_src) disable iff (!rst_n)
      $rose(half_rise) |-> $fell(cpu_clk));

   // R8: a mode change coincides with the start of a processor period
   p_switch_on_rise_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
      !$stable(mode_fast) |-> $rose(cpu_clk));

   // R9: a frozen edge keeps every registered output
   p_freeze_hold_r9: assert property (@(posedge clk_src) disable iff (!rst_n)
      !run_en |=> ($stable(cpu_clk) && $stable(per_clk) && $stable(mode_fast)));
endmodule

// File: tb/dual_speed_clkdiv_test.sv
`timescale 1ns/1ps
module dual_speed_clkdiv_test;
   localparam int FD = 3, SD = 768, PD = 6, SH = 195, FH = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic speed_sel = 1'b1;
   logic run_en = 1'b1;
   logic cpu_clk, half_clk, per_clk, mode_fast;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // model state
   int  m_ph, m_qc, m_pc;
   bit  m_fast, m_req, m_rise, m_tail;

   always #10 clk = ~clk;

   dual_speed_clkdiv uut (
      .clk_src(clk), .rst_n(rst_n), .speed_sel(speed_sel), .run_en(run_en),
      .cpu_clk(cpu_clk), .half_clk(half_clk), .per_clk(per_clk), .mode_fast(mode_fast));

   function automatic int period(input bit f);
      return f ? FD : SD;
   endfunction

   function automatic bit exp_cpu(input int ph, input bit f);
      return ph < period(f) / 3;
   endfunction

   function automatic bit exp_rise(input int ph, input bit f);
      int hi = period(f) / 3;
      return (ph >= hi) && (ph < hi + period(f) / 2);
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   task automatic model_edge(input bit s, input bit r);
      bit old_req;
      if (!r) return;
      old_req = m_req;
      if (s == m_req) m_qc = 0;
      else if (m_qc == (s ? FH - 1 : SH - 1)) begin m_req = s; m_qc = 0; end
      else m_qc++;
      if (m_ph == period(m_fast) - 1) begin m_ph = 0; m_fast = old_req; end
      else m_ph++;
      m_pc = (m_pc == PD - 1) ? 0 : m_pc + 1;
      m_rise = exp_rise(m_ph, m_fast);
   endtask

   task automatic check_all(input bit with_tail);
      chk("R2 R3 cpu_clk", cpu_clk, exp_cpu(m_ph, m_fast));
      chk("R5 per_clk", per_clk, m_pc < PD / 2);
      chk("R6 R7 R8 mode_fast", mode_fast, m_fast);
      chk("R4 half_clk", half_clk, m_rise | (with_tail & m_tail));
   endtask

   // inputs set after the falling edge; samples at +5 and +15 after rising edge
   task automatic tick(input bit s, input bit r);
      speed_sel = s;
      run_en = r;
      @(posedge clk);
      model_edge(s, r);
      #5 check_all(1'b1);
      @(negedge clk);
      m_tail = m_rise & ((period(m_fast) % 2) != 0);
      #5 check_all(1'b0);
      #2;
   endtask

   task automatic ticks(input int n, input bit s, input bit r);
      for (int i = 0; i < n; i++) tick(s, r);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit cpu_hold, per_hold;
      void'($urandom(32'd4242));
      m_ph = FD - 1; m_qc = 0; m_pc = PD - 1;
      m_fast = 1'b1; m_req = 1'b1; m_rise = 1'b0; m_tail = 1'b0;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cpu_clk reset", cpu_clk, 1'b0);
      chk("R1 half_clk reset", half_clk, 1'b0);
      chk("R1 per_clk reset", per_clk, 1'b0);
      chk("R1 mode_fast reset", mode_fast, 1'b1);
      #2 rst_n = 1'b1;
      tick(1'b1, 1'b1);
      chk("R1 first period starts high", cpu_clk, 1'b1);
      ticks(20, 1'b1, 1'b1);

      // R6: 194 lows are noise
      ticks(194, 1'b0, 1'b1);
      ticks(8, 1'b1, 1'b1);
      chk("R6 short low ignored", mode_fast, 1'b1);

      // R6 R8: 195 lows accepted, applied at next period end
      ticks(195, 1'b0, 1'b1);
      ticks(3, 1'b0, 1'b1);
      chk("R6 R8 slow applied", mode_fast, 1'b0);
      ticks(1600, 1'b0, 1'b1);

      // R7: 5 highs are noise
      ticks(5, 1'b1, 1'b1);
      ticks(800, 1'b0, 1'b1);
      chk("R7 short high ignored", mode_fast, 1'b0);

      // R7: 6 highs accepted, applied within one slow period
      ticks(6, 1'b1, 1'b1);
      ticks(770, 1'b1, 1'b1);
      chk("R7 fast applied", mode_fast, 1'b1);

      // R9 freeze in fast mode at several phases
      for (int k = 0; k < 6; k++) begin
         ticks(k + 1, 1'b1, 1'b1);
         cpu_hold = cpu_clk; per_hold = per_clk;
         ticks(7, 1'b0, 1'b0);
         chk("R9 cpu held", cpu_clk, cpu_hold);
         chk("R9 per held", per_clk, per_hold);
         chk("R9 mode held", mode_fast, 1'b1);
      end

      // R5 R9 freeze in slow mode across a pending request
      ticks(200, 1'b0, 1'b1);
      ticks(800, 1'b0, 1'b1);
      chk("R3 slow for freeze test", mode_fast, 1'b0);
      ticks(3, 1'b1, 1'b1);
      ticks(50, 1'b1, 1'b0);
      ticks(3, 1'b1, 1'b1);
      ticks(770, 1'b1, 1'b1);
      chk("R9 filter progress kept", mode_fast, 1'b1);

      // random segments, model checked every half cycle
      for (int seg = 0; seg < 160; seg++) begin
         int len = 1 + ($urandom % 300);
         bit s = $urandom % 2;
         for (int i = 0; i < len; i++) tick(s, ($urandom % 10) != 0);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule